// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Group

This block holds a small group of independent down-counting timer channels that share one interrupt status word. Each channel has a control word, an initial count and a readable current count. An 8-bit prescale value in the control word slows the count. With a prescale value P, the count falls by one every P+1 clocks while the channel is enabled.

When a channel's count runs out, the channel sets its own bit in the shared status word. In one-shot mode the channel then switches itself off. In periodic mode it reloads from its initial count and keeps running. Each channel drives its own interrupt line, which is high while its status bit is set and its interrupt enable is on. Software clears status bits by writing ones to them.

Registers sit on a flat address: the low two bits select the register kind (0 control, 1 initial count, 2 current count, 3 status) and the bits above select the channel. Writes take effect at the clock edge. Reads are combinational from the same address. The asynchronous active-low reset is released through a two-stage synchronizer, so the block starts counting two clocks after `rst_n` rises.

Top module: `tmr_group`

## Requirements
- R1: After reset, every control word reads 0x00000005 (prescale 5, all other bits zero). Every initial count, every current count and the status word read 0, and every interrupt line is low.
- R2: Control bit 16 enables the channel. While it is set, the count drops by one every P+1 clocks, where P is control bits [7:0]. A channel enabled with count N reaches its zero event N·(P+1) clocks after the enabling write.
- R3: Control bit 19 is a read-only active flag. It goes to 1 when a write takes the enable bit from 0 to 1. It goes to 0 when the enable bit goes from 1 to 0, and the count then stays frozen.
- R4: With control bit 18 clear (one-shot), the zero event leaves the count at 0 and clears both the enable bit and the active flag.
- R5: With control bit 18 set (periodic), the zero event reloads the count from the initial count, and the channel keeps running with the same period.
- R6: A zero event sets status bit i for channel i. Writing the status register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R7: Interrupt line i is high exactly when status bit i is set and control bit 17 (interrupt enable) of channel i is set.
- R8: A write that clears the enable bit while the count is already 0 takes the zero event, so the channel's status bit becomes set.
- R9: Changing the prescale value while the channel runs keeps the current count and continues at the new rate, starting a fresh prescale period.
- R10: Writing the initial count loads that value into the current count at once. A running channel keeps counting from it; a stopped channel stays frozen at it.
- R11: Writes to the current-count register change nothing, and a write to the active flag has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W (3) | {channel, register kind} |
| wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Combinational read of the register at `addr` |
| irq | output | NUM_CH (2) | Per-channel interrupt lines |

## Verification
The hardest state to reach is a running channel whose count is already zero at the moment it is disabled (R8). A one-shot expiry leaves the count at 0. The bench then re-enables the channel with the largest prescale value, so no decrement can happen, and disables it on the very next write. Only the disable can then set the status bit. The prescale-change case is aimed just as precisely: the rate is switched between two ticks, and the count is sampled at clock counts derived from the old and new rates.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_INIT  = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } reg_kind_e;

  localparam int PRE_W   = 8;
  localparam int EN_BIT  = 16;
  localparam int IE_BIT  = 17;
  localparam int PER_BIT = 18;
  localparam int ACT_BIT = 19;
  localparam logic [PRE_W-1:0] PRESC_RST = 8'd5;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_limit;

  assign at_limit = (pre_q == limit);
  assign tick     = run && !hold && at_limit;

  always_comb begin
    pre_d = pre_q;
    if (restart)
      pre_d = '0;
    else if (run && !hold)
      pre_d = at_limit ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2: with a nonzero prescale two ticks are never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              init_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [CNT_W-1:0]  init_val,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              zero_evt,
  output logic              irq_en
);
  logic             en_q, en_d, act_q, act_d, ie_q, ie_d, per_q, per_d;
  logic [PRE_W-1:0] presc_q, presc_d;
  logic [CNT_W-1:0] init_q, init_d, cnt_q, cnt_d;
  logic             pre_clr, tick, any_we, w_en;

  generate
    if (CNT_W < DATA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:CNT_W];
    end
  endgenerate

  assign any_we = ctrl_we || init_we;
  assign w_en   = wdata[EN_BIT];

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .hold    (any_we),
    .restart (pre_clr),
    .limit   (presc_q),
    .tick    (tick)
  );

  always_comb begin
    en_d     = en_q;
    act_d    = act_q;
    ie_d     = ie_q;
    per_d    = per_q;
    presc_d  = presc_q;
    init_d   = init_q;
    cnt_d    = cnt_q;
    zero_evt = 1'b0;
    pre_clr  = 1'b0;
    if (ctrl_we) begin
      en_d    = w_en;
      ie_d    = wdata[IE_BIT];
      per_d   = wdata[PER_BIT];
      presc_d = wdata[PRE_W-1:0];
      if (presc_d != presc_q) pre_clr = 1'b1;
      if (!en_q && w_en) begin
        act_d   = 1'b1;
        pre_clr = 1'b1;
      end else if (en_q && !w_en) begin
        act_d = 1'b0;
        if (cnt_q == '0) begin
          zero_evt = 1'b1;
          if (per_d) cnt_d = init_q;
        end
      end
    end else if (init_we) begin
      init_d  = wdata[CNT_W-1:0];
      cnt_d   = wdata[CNT_W-1:0];
      pre_clr = 1'b1;
    end else if (tick) begin
      if (cnt_q <= CNT_W'(1)) begin
        zero_evt = 1'b1;
        if (per_q) begin
          cnt_d = init_q;
        end else begin
          cnt_d = '0;
          en_d  = 1'b0;
          act_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      ie_q    <= 1'b0;
      per_q   <= 1'b0;
      presc_q <= PRESC_RST;
      init_q  <= '0;
      cnt_q   <= '0;
    end else begin
      en_q    <= en_d;
      act_q   <= act_d;
      ie_q    <= ie_d;
      per_q   <= per_d;
      presc_q <= presc_d;
      init_q  <= init_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[PRE_W-1:0] = presc_q;
    ctrl_word[EN_BIT]    = en_q;
    ctrl_word[IE_BIT]    = ie_q;
    ctrl_word[PER_BIT]   = per_q;
    ctrl_word[ACT_BIT]   = act_q;
  end

  assign init_val = init_q;
  assign cnt_val  = cnt_q;
  assign irq_en   = ie_q;

  a_r3_active_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    act_q == en_q);
  a_r4_oneshot_off: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !ctrl_we && !per_q) |=> (!en_q && !act_q && cnt_q == '0));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !ctrl_we && per_q) |=> cnt_q == $past(init_q));
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !any_we) |=> $stable(cnt_q));
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic [NUM_CH-1:0] ie,
  output logic [NUM_CH-1:0] status,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0] stat_q, stat_d, clr_v;

  assign clr_v = clr_we ? clr_mask : '0;

  always_comb stat_d = (stat_q & ~clr_v) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
  assign irq    = stat_q & ie;

  a_r6_set_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
  a_r6_clear_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt == '0) |=> ((status & $past(clr_mask)) == '0));
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~ie) == '0);
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] irq
);
  logic [1:0]        rst_sync;
  logic              core_rst_n;
  reg_kind_e         kind;
  logic [CH_W-1:0]   ch_sel;
  logic              ch_ok;
  logic [DATA_W-1:0] ctrl_w [NUM_CH];
  logic [CNT_W-1:0]  init_w [NUM_CH];
  logic [CNT_W-1:0]  cnt_w  [NUM_CH];
  logic [NUM_CH-1:0] evt, ie, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  assign kind   = reg_kind_e'(addr[1:0]);
  assign ch_sel = addr[ADDR_W-1:2];
  assign ch_ok  = int'(ch_sel) < NUM_CH;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = wr_en && (ch_sel == CH_W'(i));
      tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .ctrl_we   (hit && kind == REG_CTRL),
        .init_we   (hit && kind == REG_INIT),
        .wdata     (wdata),
        .ctrl_word (ctrl_w[i]),
        .init_val  (init_w[i]),
        .cnt_val   (cnt_w[i]),
        .zero_evt  (evt[i]),
        .irq_en    (ie[i])
      );
    end
  endgenerate

  tmr_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .evt      (evt),
    .clr_we   (wr_en && kind == REG_STAT),
    .clr_mask (wdata[NUM_CH-1:0]),
    .ie       (ie),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    rd_data = '0;
    if (kind == REG_STAT) begin
      rd_data[NUM_CH-1:0] = status;
    end else if (ch_ok) begin
      case (kind)
        REG_CTRL:  rd_data = ctrl_w[ch_sel];
        REG_INIT:  rd_data[CNT_W-1:0] = init_w[ch_sel];
        REG_COUNT: rd_data[CNT_W-1:0] = cnt_w[ch_sel];
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: tb/sim_tmr_group.sv
module sim_tmr_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_group u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int ch, input int kind, input logic [31:0] d);
    addr  = {ch[0], kind[1:0]};
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int kind, output logic [31:0] d);
    addr = {ch[0], kind[1:0]};
    #1 d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int c = 0; c < 2; c++) begin
      rd(c, 0, v); chk("R1 ctrl", v, 32'h5);
      rd(c, 1, v); chk("R1 init", v, 32'h0);
      rd(c, 2, v); chk("R1 count", v, 32'h0);
    end
    rd(0, 3, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", {30'b0, irq}, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(0, 1, 32'd10);
    wr(0, 0, 32'h0003_0002);
    rd(0, 0, v); chk("R3 active set", v, 32'h000B_0002);
    wait_cyc(29);
    rd(0, 2, v); chk("R2 count before zero", v, 32'd1);
    rd(0, 3, v); chk("R2 no early event", v, 32'h0);
    wait_cyc(1);
    rd(0, 3, v); chk("R2 R6 event at N(P+1)", v, 32'h1);
    rd(0, 2, v); chk("R4 count stays zero", v, 32'h0);
    rd(0, 0, v); chk("R4 en and active cleared", v, 32'h0002_0002);
    chk("R7 irq with enable", {30'b0, irq}, 32'h1);
    wr(0, 3, 32'h0);
    rd(0, 3, v); chk("R6 write zero keeps", v, 32'h1);
    wr(0, 3, 32'h1);
    rd(0, 3, v); chk("R6 write one clears", v, 32'h0);
    chk("R7 irq drops", {30'b0, irq}, 32'h0);
  endtask

  task automatic t_irq_masked();
    logic [31:0] v;
    wr(1, 1, 32'd3);
    wr(1, 0, 32'h0001_0000);
    wait_cyc(3);
    rd(1, 3, v); chk("R6 ch1 event", v, 32'h2);
    chk("R7 irq masked", {30'b0, irq}, 32'h0);
    wr(1, 3, 32'h2);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(0, 1, 32'd4);
    wr(0, 0, 32'h0005_0001);
    wait_cyc(8);
    rd(0, 3, v); chk("R5 first event", v, 32'h1);
    rd(0, 2, v); chk("R5 reload", v, 32'd4);
    rd(0, 0, v); chk("R5 still running", v, 32'h000D_0001);
    wr(0, 3, 32'h1);
    wait_cyc(6);
    rd(0, 3, v); chk("R5 no event mid period", v, 32'h0);
    rd(0, 2, v); chk("R5 count mid period", v, 32'd1);
    wait_cyc(1);
    rd(0, 3, v); chk("R5 second event", v, 32'h1);
    wr(0, 0, 32'h0004_0001);
    rd(0, 0, v); chk("R3 active cleared", v, 32'h0004_0001);
    wait_cyc(10);
    rd(0, 2, v); chk("R3 count frozen", v, 32'd4);
    wr(0, 3, 32'h1);
  endtask

  task automatic t_disable_zero();
    logic [31:0] v;
    wr(1, 0, 32'h0001_00FF);
    rd(1, 3, v); chk("R8 no event while enabled", v, 32'h0);
    wr(1, 0, 32'h0000_00FF);
    rd(1, 3, v); chk("R8 disable at zero sets status", v, 32'h2);
    wr(1, 3, 32'h2);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(0, 1, 32'd20);
    wr(0, 0, 32'h0001_0003);
    wait_cyc(8);
    rd(0, 2, v); chk("R9 count at old rate", v, 32'd18);
    wr(0, 0, 32'h0001_0000);
    rd(0, 2, v); chk("R9 count kept", v, 32'd18);
    wait_cyc(5);
    rd(0, 2, v); chk("R9 count at new rate", v, 32'd13);
    rd(0, 0, v); chk("R9 still active", v, 32'h0009_0000);
    wr(0, 0, 32'h0);
  endtask

  task automatic t_init_restart();
    logic [31:0] v;
    wr(0, 1, 32'd7);
    wait_cyc(5);
    rd(0, 2, v); chk("R10 stopped load", v, 32'd7);
    wr(0, 0, 32'h0001_0000);
    wait_cyc(2);
    rd(0, 2, v); chk("R10 running from init", v, 32'd5);
    wr(0, 1, 32'd30);
    rd(0, 2, v); chk("R10 restart value", v, 32'd30);
    wait_cyc(3);
    rd(0, 2, v); chk("R10 keeps running", v, 32'd27);
    wr(0, 0, 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(0, 2, 32'h55);
    rd(0, 2, v); chk("R11 count write ignored", v, 32'd27);
    wr(0, 0, 32'h0008_0000);
    rd(0, 0, v); chk("R11 active write ignored", v, 32'h0);
    wait_cyc(4);
    rd(0, 2, v); chk("R11 count unchanged", v, 32'd27);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_oneshot();
    t_irq_masked();
    t_periodic();
    t_disable_zero();
    t_prescale();
    t_init_restart();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule